// File: doc/BRIEF.md
# Event Timer Global Control Block

This block is the shared front end of a multi-channel event timer. It owns the main counter and the global registers that all channels share. It also decides which bus accesses fall into the per-channel register slots. The block sits in a 1 KiB register window on a bus that carries 32-bit and 64-bit accesses. Reads return data one cycle after the request. Writes take effect at the clock edge that accepts them.

The main counter is 64 bits wide. It advances by one on every tick, and a tick comes once every `TICK_DIV` system clocks. It counts only while the global run bit is set. When the run bit clears, the counter keeps its value, and it continues from that value when the run bit is set again. The timer channels raise per-channel set requests. The block collects these in a sticky status register. Software clears a status bit by writing a one to it. The block then gives the owning channel a one-cycle pulse telling it to drop its interrupt.

The block exports these signals to the channels: the run bit, the legacy-route bit, the counter value, the tick strobe, the status bits, and a decoded slot strobe carrying the channel index, the slot kind and the half select.

Top module: `evtg_glb_ctrl`

## Requirements
- R1: A read of the identity word at offset 0x000 returns the following fields. Writes to this word change nothing.
  - bits 7:0 hold 0x01.
  - bits 12:8 hold the effective channel count minus one.
  - bit 13 is 1.
  - bit 14 is 0.
  - bit 15 is 1.
  - bits 31:16 hold `VENDOR_ID`.
  - bits 63:32 hold `PERIOD_FS`, the tick period in femtoseconds (default 10,000,000).
- R2: The control word at offset 0x010 has two writable bits: bit 0 is run and bit 1 is legacy route. All other bits read as 0. `ev_enable` and `ev_legacy` follow bits 0 and 1. The control word changes only when it is written.
- R3: While run is set, the counter grows by one every `TICK_DIV` clocks. The first increment comes `TICK_DIV` clocks after the edge that sets run. While run is clear, the counter holds its value, and it resumes from that value when run is set again.
- R4: While run is clear, a write to offset 0x0F0 loads the addressed part of the counter. A read of 0x0F0 returns the counter value as it stood in the request cycle.
- R5: Address bit 2 selects the upper 32 bits of any 64-bit register.
  - With bit 2 clear, a 64-bit access covers all 64 bits and a 32-bit access covers bits 31:0.
  - With bit 2 set, either access width reaches only bits 63:32, using data bits 31:0.
  - A 32-bit read returns zeros in `bus_rdata[63:32]`.
- R6: For channels below the effective count, a set request raises the status bit at offset 0x020 at the next edge. The bit stays set until it is cleared.
- R7: A write of one to a set status bit clears it at the accepting edge and pulses the matching `int_clear` bit for exactly one cycle after that edge. Writing 0, or writing one to a clear bit, changes nothing and gives no pulse. If a set request for that channel arrives in the same cycle, the set request wins: the bit stays set and no pulse is given.
- R8: Offset 0x100 + N*0x20 + S, for N below the effective count and S equal to 0x0, 0x8 or 0x10 (bit 2 ignored), is channel N's slot. S = 0x0 gives kind 0, 0x8 gives kind 1 and 0x10 gives kind 2.
  - In the request cycle, `tmr_access` is high and `tmr_index`, `tmr_slot` and `tmr_upper` describe the access.
  - A read of such a slot returns `timer_rdata`, with the same half selection as R5.
- R9: Unmapped addresses read as 0, change no register and raise no slot strobe. These are:
  - global offsets other than the four listed;
  - slot offset 0x18;
  - channel indices at or above the effective count.
- R10: While reset is asserted, the control word, counter, status bits, clear pulses and read data are all 0.
- R11: The effective channel count is `NUM_TIMERS` clamped to the range 3 to 32. Status and set-request bits at or above that count stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | 10 | Byte offset within the window |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid the cycle after a read |
| timer_rdata | input | 64 | Full 64-bit value of the addressed channel slot |
| tmr_access | output | 1 | Request targets a channel slot |
| tmr_write | output | 1 | The slot access is a write |
| tmr_index | output | 5 | Channel number of the slot |
| tmr_slot | output | 2 | Slot kind: 0 config, 1 compare, 2 message route |
| tmr_upper | output | 1 | Access targets the upper 32 bits |
| ev_enable | output | 1 | Global run bit |
| ev_legacy | output | 1 | Legacy-route bit |
| ev_count | output | 64 | Main counter value |
| ev_tick | output | 1 | Tick strobe; the counter advances at this edge |
| int_set | input | 32 | Per-channel status set requests |
| int_status | output | 32 | Sticky per-channel status bits |
| int_clear | output | 32 | One-cycle deassert pulses after a write-one clear |

## Verification
Some properties are checked every cycle:
- the counter holds while it is neither running nor being loaded;
- the counter steps by exactly one on each tick;
- every status bit that falls matches a clear pulse, and every pulse comes from a bit that was set;
- the control word stays put with no write;
- unmapped reads return zero;
- slot indices stay below the channel count.

Other behaviour needs the bench's scenarios:
- the identity word's field layout and its clamping under other channel counts;
- the exact tick count across stop and resume, including a carry across the 32-bit boundary;
- half-word selection for both access widths;
- the same-cycle contest between a set request and a clear.

// File: rtl/evtg_pkg.sv
package evtg_pkg;

  localparam int WIN_AW  = 10;   // 1 KiB register window
  localparam int MAX_TMR = 32;
  localparam int MIN_TMR = 3;
  localparam logic [WIN_AW-1:0] TMR_BASE = 10'h100;

  typedef enum logic [2:0] {
    K_NONE,
    K_CAP,
    K_CFG,
    K_STS,
    K_CNT,
    K_TMR
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic       upper;
    logic [4:0] tidx;
    logic [1:0] slot;
  } dec_t;

  function automatic int clamp_tmr(int n);
    if (n < MIN_TMR) return MIN_TMR;
    if (n > MAX_TMR) return MAX_TMR;
    return n;
  endfunction

endpackage

// File: rtl/evtg_addr_dec.sv
module evtg_addr_dec
  import evtg_pkg::*;
#(
  parameter int NUM_TMR = 3
) (
  input  logic [WIN_AW-1:0] addr,
  output dec_t              dec
);

  localparam logic [5:0] NT6 = 6'(NUM_TMR);

  logic [WIN_AW-1:0] a_al;
  logic [WIN_AW-1:0] off;

  always_comb begin
    a_al      = addr;
    a_al[2]   = 1'b0;
    off       = a_al - TMR_BASE;
    dec.kind  = K_NONE;
    dec.upper = addr[2];
    dec.tidx  = '0;
    dec.slot  = '0;
    if (a_al < TMR_BASE) begin
      case (a_al[7:0])
        8'h00:   dec.kind = K_CAP;
        8'h10:   dec.kind = K_CFG;
        8'h20:   dec.kind = K_STS;
        8'hF0:   dec.kind = K_CNT;
        default: dec.kind = K_NONE;
      endcase
    end else if (({1'b0, off[WIN_AW-1:5]} < NT6) &&
                 (off[4:3] != 2'b11) && (off[2:0] == 3'b000)) begin
      dec.kind = K_TMR;
      dec.tidx = off[WIN_AW-1:5];
      dec.slot = off[4:3];
    end
  end

endmodule

// File: rtl/evtg_main_counter.sv
module evtg_main_counter #(
  parameter int TICK_DIV = 4,
  parameter int CNT_W    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_mask,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] count,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  generate
    if (TICK_DIV <= 1) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] div_q, div_d;

      always_comb begin
        if (!run || (div_q == DIV_LAST)) div_d = '0;
        else                             div_d = div_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      assign tick = run && (div_q == DIV_LAST);
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (ld_en)     cnt_d = (cnt_q & ~ld_mask) | (ld_val & ld_mask);
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R3: a counter that is neither running nor loaded keeps its value
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_en) |=> $stable(count));

  // R3: each tick adds exactly one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_en) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/evtg_int_status.sv
module evtg_int_status
  import evtg_pkg::*;
#(
  parameter int NUM_TMR = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MAX_TMR-1:0] set_req,
  input  logic               clr_en,
  input  logic [MAX_TMR-1:0] clr_mask,
  output logic [MAX_TMR-1:0] status,
  output logic [MAX_TMR-1:0] clr_pulse
);

  localparam logic [MAX_TMR-1:0] LIVE = MAX_TMR'((64'h1 << NUM_TMR) - 64'h1);

  logic [MAX_TMR-1:0] sts_q, sts_d, pls_q, pls_d;

  always_comb begin
    pls_d = '0;
    if (clr_en) pls_d = clr_mask & sts_q & ~set_req & LIVE;
    sts_d = (sts_q & ~pls_d) | (set_req & LIVE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      pls_q <= '0;
    end else begin
      sts_q <= sts_d;
      pls_q <= pls_d;
    end
  end

  assign status    = sts_q;
  assign clr_pulse = pls_q;

  // R7: bits that fell are exactly the bits pulsed
  p_fall_is_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~status) == clr_pulse));

  // R7: a pulse only targets a bit that was set
  p_pulse_was_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_pulse & ~$past(status)) == '0));

endmodule

// File: rtl/evtg_glb_ctrl.sv
module evtg_glb_ctrl
  import evtg_pkg::*;
#(
  parameter int          NUM_TIMERS = 8,
  parameter int          TICK_DIV   = 4,
  parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
  parameter logic [31:0] PERIOD_FS  = 32'd10_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic               bus_wide,
  input  logic [WIN_AW-1:0]  bus_addr,
  input  logic [63:0]        bus_wdata,
  output logic [63:0]        bus_rdata,
  input  logic [63:0]        timer_rdata,
  output logic               tmr_access,
  output logic               tmr_write,
  output logic [4:0]         tmr_index,
  output logic [1:0]         tmr_slot,
  output logic               tmr_upper,
  output logic               ev_enable,
  output logic               ev_legacy,
  output logic [63:0]        ev_count,
  output logic               ev_tick,
  input  logic [MAX_TMR-1:0] int_set,
  output logic [MAX_TMR-1:0] int_status,
  output logic [MAX_TMR-1:0] int_clear
);

  localparam int NT = clamp_tmr(NUM_TIMERS);
  localparam logic [63:0] ID_WORD =
    {PERIOD_FS, VENDOR_ID, 1'b1, 1'b0, 1'b1, 5'(NT - 1), 8'h01};

  dec_t        dec;
  logic        do_wr, do_rd;
  logic [63:0] wr_mask, wr_val;
  logic [1:0]  cfg_q, cfg_d;
  logic [63:0] rd_q, rd_d, reg_full, rd_sh;
  logic        cnt_ld, sts_clr;

  evtg_addr_dec #(.NUM_TMR(NT)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  always_comb begin
    do_wr = bus_valid && bus_write;
    do_rd = bus_valid && !bus_write;
    if (dec.upper) begin
      wr_mask = {32'hFFFF_FFFF, 32'h0};
      wr_val  = {bus_wdata[31:0], 32'h0};
    end else if (bus_wide) begin
      wr_mask = '1;
      wr_val  = bus_wdata;
    end else begin
      wr_mask = {32'h0, 32'hFFFF_FFFF};
      wr_val  = {32'h0, bus_wdata[31:0]};
    end
  end

  always_comb begin
    cfg_d = cfg_q;
    if (do_wr && dec.kind == K_CFG)
      cfg_d = (cfg_q & ~wr_mask[1:0]) | (wr_val[1:0] & wr_mask[1:0]);
  end

  assign cnt_ld  = do_wr && (dec.kind == K_CNT);
  assign sts_clr = do_wr && (dec.kind == K_STS);

  evtg_main_counter #(.TICK_DIV(TICK_DIV), .CNT_W(64)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cfg_q[0]),
    .ld_en   (cnt_ld),
    .ld_mask (wr_mask),
    .ld_val  (wr_val),
    .count   (ev_count),
    .tick    (ev_tick)
  );

  evtg_int_status #(.NUM_TMR(NT)) u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_req   (int_set),
    .clr_en    (sts_clr),
    .clr_mask  (wr_val[MAX_TMR-1:0] & wr_mask[MAX_TMR-1:0]),
    .status    (int_status),
    .clr_pulse (int_clear)
  );

  always_comb begin
    case (dec.kind)
      K_CAP:   reg_full = ID_WORD;
      K_CFG:   reg_full = {62'h0, cfg_q};
      K_STS:   reg_full = {32'h0, int_status};
      K_CNT:   reg_full = ev_count;
      K_TMR:   reg_full = timer_rdata;
      default: reg_full = '0;
    endcase
    rd_sh = dec.upper ? {32'h0, reg_full[63:32]} : reg_full;
    if (!bus_wide) rd_sh[63:32] = 32'h0;
    rd_d = do_rd ? rd_sh : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      rd_q  <= '0;
    end else begin
      cfg_q <= cfg_d;
      rd_q  <= rd_d;
    end
  end

  assign bus_rdata  = rd_q;
  assign ev_enable  = cfg_q[0];
  assign ev_legacy  = cfg_q[1];
  assign tmr_access = bus_valid && (dec.kind == K_TMR);
  assign tmr_write  = bus_write;
  assign tmr_index  = dec.tidx;
  assign tmr_slot   = dec.slot;
  assign tmr_upper  = dec.upper;

  // R2: control word moves only on a write
  p_cfg_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !do_wr |=> $stable({ev_enable, ev_legacy}));

  // R9: unmapped reads return zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && dec.kind == K_NONE) |=> (bus_rdata == 64'h0));

  // R8: slot strobe only for channels that exist
  p_slot_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_access |-> ({1'b0, tmr_index} < 6'(NT)));

endmodule

// File: tb/evtg_glb_ctrl_test.sv
module evtg_glb_ctrl_test;

  localparam int NT   = 8;
  localparam int DIV  = 4;
  localparam logic [15:0] VID = 16'hA5C3;
  localparam logic [31:0] PFS = 32'd10_000_000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write, bus_wide;
  logic [9:0]  bus_addr;
  logic [63:0] bus_wdata, bus_rdata, timer_rdata;
  logic        tmr_access, tmr_write, tmr_upper;
  logic [4:0]  tmr_index;
  logic [1:0]  tmr_slot;
  logic        ev_enable, ev_legacy, ev_tick;
  logic [63:0] ev_count;
  logic [31:0] int_set, int_status, int_clear;

  logic [63:0] lo_rdata, hi_rdata, lo_cnt, hi_cnt;
  logic        lo_acc, lo_w, lo_up, lo_en, lo_leg, lo_tk;
  logic        hi_acc, hi_w, hi_up, hi_en, hi_leg, hi_tk;
  logic [4:0]  lo_idx, hi_idx;
  logic [1:0]  lo_sl, hi_sl;
  logic [31:0] lo_st, lo_cl, hi_st, hi_cl;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  evtg_glb_ctrl #(.NUM_TIMERS(NT), .TICK_DIV(DIV), .VENDOR_ID(VID), .PERIOD_FS(PFS)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .timer_rdata(timer_rdata), .tmr_access(tmr_access),
    .tmr_write(tmr_write), .tmr_index(tmr_index), .tmr_slot(tmr_slot),
    .tmr_upper(tmr_upper), .ev_enable(ev_enable), .ev_legacy(ev_legacy),
    .ev_count(ev_count), .ev_tick(ev_tick), .int_set(int_set),
    .int_status(int_status), .int_clear(int_clear));

  evtg_glb_ctrl #(.NUM_TIMERS(1), .TICK_DIV(DIV), .VENDOR_ID(VID), .PERIOD_FS(PFS)) uut_lo (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(lo_rdata), .timer_rdata(timer_rdata), .tmr_access(lo_acc),
    .tmr_write(lo_w), .tmr_index(lo_idx), .tmr_slot(lo_sl),
    .tmr_upper(lo_up), .ev_enable(lo_en), .ev_legacy(lo_leg),
    .ev_count(lo_cnt), .ev_tick(lo_tk), .int_set(int_set),
    .int_status(lo_st), .int_clear(lo_cl));

  evtg_glb_ctrl #(.NUM_TIMERS(40), .TICK_DIV(DIV), .VENDOR_ID(VID), .PERIOD_FS(PFS)) uut_hi (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(hi_rdata), .timer_rdata(timer_rdata), .tmr_access(hi_acc),
    .tmr_write(hi_w), .tmr_index(hi_idx), .tmr_slot(hi_sl),
    .tmr_upper(hi_up), .ev_enable(hi_en), .ev_legacy(hi_leg),
    .ev_count(hi_cnt), .ev_tick(hi_tk), .int_set(int_set),
    .int_status(hi_st), .int_clear(hi_cl));

  function automatic logic [63:0] id_word(int nt);
    return {PFS, VID, 1'b1, 1'b0, 1'b1, 5'(nt - 1), 8'h01};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic bus_wr(logic [9:0] a, logic [63:0] d, logic wide);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_wide = wide;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  logic        s_acc, s_up;
  logic [4:0]  s_idx;
  logic [1:0]  s_slot;

  task automatic bus_rd(logic [9:0] a, logic wide, output logic [63:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wide = wide;
    #1;
    s_acc = tmr_access; s_up = tmr_upper; s_idx = tmr_index; s_slot = tmr_slot;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  logic [63:0] rd, base, cexp;
  logic [31:0] model;

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    rst_n = 1'b0; bus_valid = 0; bus_write = 0; bus_wide = 0; bus_addr = '0;
    bus_wdata = '0; timer_rdata = '0; int_set = '0;
    idle(3);
    // R10 reset state
    chk("R10 rdata", bus_rdata, 0);
    chk("R10 cfg", {62'h0, ev_legacy, ev_enable}, 0);
    chk("R10 count", ev_count, 0);
    chk("R10 status", {32'h0, int_status}, 0);
    chk("R10 clear", {32'h0, int_clear}, 0);
    rst_n = 1'b1;
    idle(1);

    // R1 identity word, R11 clamping
    bus_rd(10'h000, 1'b1, rd);
    chk("R1 id word", rd, id_word(NT));
    chk("R11 clamp low", {59'h0, lo_rdata[12:8]}, 64'd2);
    chk("R11 clamp high", {59'h0, hi_rdata[12:8]}, 64'd31);
    bus_rd(10'h004, 1'b0, rd);
    chk("R5 id upper half", rd, {32'h0, PFS});
    bus_rd(10'h000, 1'b0, rd);
    chk("R5 id lower 32-bit", rd, {32'h0, id_word(NT)[31:0]});
    bus_wr(10'h000, 64'h0, 1'b1);
    bus_rd(10'h000, 1'b1, rd);
    chk("R1 write ignored", rd, id_word(NT));

    // R2 control word
    bus_wr(10'h010, '1, 1'b1);
    bus_rd(10'h010, 1'b1, rd);
    chk("R2 only two bits", rd, 64'h3);
    chk("R2 exports", {62'h0, ev_legacy, ev_enable}, 64'h3);
    bus_wr(10'h010, 64'h0, 1'b1);
    bus_wr(10'h014, 64'hFFFF_FFFF, 1'b0);
    bus_rd(10'h010, 1'b1, rd);
    chk("R5 upper write leaves ctrl", rd, 64'h0);
    bus_wr(10'h010, 64'h2, 1'b0);
    chk("R2 legacy only", {62'h0, ev_legacy, ev_enable}, 64'h2);

    // R4 / R5 counter load while halted
    bus_wr(10'h0F0, 64'h0000_0001_FFFF_FFF0, 1'b1);
    bus_rd(10'h0F0, 1'b1, rd);
    chk("R4 load 64", rd, 64'h0000_0001_FFFF_FFF0);
    bus_wr(10'h0F4, 64'h5, 1'b0);
    bus_wr(10'h0F0, 64'hFFFF_FFFE, 1'b0);
    bus_rd(10'h0F0, 1'b0, rd);
    chk("R5 counter low 32", rd, 64'hFFFF_FFFE);
    bus_rd(10'h0F4, 1'b1, rd);
    chk("R5 counter high", rd, 64'h5);
    base = 64'h0000_0005_FFFF_FFFE;

    // R3 run, stop, hold, resume
    bus_wr(10'h010, 64'h1, 1'b0);
    idle(9);
    bus_wr(10'h010, 64'h0, 1'b0);
    cexp = base + 64'((9 + 1) / DIV);
    bus_rd(10'h0F0, 1'b1, rd);
    chk("R3 count across carry", rd, cexp);
    idle(20);
    bus_rd(10'h0F0, 1'b1, rd);
    chk("R3 hold while stopped", rd, cexp);
    bus_wr(10'h010, 64'h1, 1'b0);
    idle(7);
    bus_rd(10'h0F0, 1'b1, rd);
    chk("R4 live read", rd, cexp + 64'(7 / DIV));
    bus_wr(10'h010, 64'h0, 1'b0);
    cexp = cexp + 64'(9 / DIV);
    bus_rd(10'h0F0, 1'b1, rd);
    chk("R3 resume from held", rd, cexp);

    // R9 unmapped
    bus_wr(10'h008, '1, 1'b1);
    bus_wr(10'h200, '1, 1'b1);
    bus_wr(10'h118, '1, 1'b1);
    bus_rd(10'h010, 1'b1, rd);
    chk("R9 ctrl untouched", rd, 64'h0);
    bus_rd(10'h0F0, 1'b1, rd);
    chk("R9 counter untouched", rd, cexp);
    timer_rdata = 64'hDEAD_BEEF_0123_4567;
    bus_rd(10'h030, 1'b1, rd);
    chk("R9 gap read", rd, 0);
    bus_rd(10'h118, 1'b1, rd);
    chk("R9 slot 0x18 read", rd, 0);
    chk("R9 slot 0x18 strobe", {63'h0, s_acc}, 0);

    // R8 directed slot
    bus_rd(10'h16C, 1'b0, rd);
    chk("R8 strobe", {63'h0, s_acc}, 1);
    chk("R8 index/slot/half", {56'h0, s_idx, s_slot, s_up}, {56'h0, 5'd3, 2'd1, 1'b1});
    chk("R8 upper data", rd, 64'h0000_0000_DEAD_BEEF);

    // R8 / R9 random slot addresses
    for (int i = 0; i < 150; i++) begin
      logic [9:0] a, al, off;
      logic       ok, wide;
      a  = 10'h100 + 10'(($urandom % 192) * 4);
      wide = 1'($urandom);
      timer_rdata = {$urandom, $urandom};
      al = a & ~10'h4;
      off = al - 10'h100;
      ok = (int'(off[9:5]) < NT) && (off[4:0] != 5'h18);
      bus_rd(a, wide, rd);
      chk("R8 random strobe", {63'h0, s_acc}, {63'h0, ok});
      if (ok) begin
        chk("R8 random decode", {56'h0, s_idx, s_slot, s_up}, {56'h0, off[9:5], off[4:3], a[2]});
        if (a[2])      chk("R8 random data", rd, {32'h0, timer_rdata[63:32]});
        else if (wide) chk("R8 random data", rd, timer_rdata);
        else           chk("R8 random data", rd, {32'h0, timer_rdata[31:0]});
      end else begin
        chk("R9 random unmapped", rd, 0);
      end
    end

    // R6 / R7 / R11 status random
    model = '0;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] setv, wm, clr;
      logic        dow;
      setv = ($urandom % 3 == 0) ? $urandom : 32'h0;
      dow  = 1'($urandom);
      wm   = $urandom;
      int_set = setv;
      if (dow) begin
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 10'h020;
        bus_wide = 1'b0; bus_wdata = {32'h0, wm};
      end
      clr = dow ? (wm & model & ~setv & 32'hFF) : 32'h0;
      @(posedge clk);
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; int_set = '0;
      model = (model & ~clr) | (setv & 32'hFF);
      chk("R6 status", {32'h0, int_status}, {32'h0, model});
      chk("R7 clear pulse", {32'h0, int_clear}, {32'h0, clr});
    end
    idle(1);
    chk("R7 pulse one cycle", {32'h0, int_clear}, 0);
    bus_rd(10'h020, 1'b1, rd);
    chk("R6 status read", rd, {32'h0, model});

    // R7 collision: set wins
    int_set = 32'h1;
    idle(1);
    int_set = 32'h1;
    bus_wr(10'h020, 64'h1, 1'b0);
    int_set = '0;
    chk("R7 set wins", {63'h0, int_status[0]}, 1);
    chk("R7 no pulse on collision", {63'h0, int_clear[0]}, 0);
    bus_wr(10'h020, 64'h0, 1'b0);
    chk("R7 zero write no effect", {63'h0, int_status[0]}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule